// File: doc/BRIEF.md
# Cache and TLB Maintenance Command Decoder

This block sits between a coprocessor register-write path and the memory-system maintenance logic. Each maintenance write arrives as a one-cycle `valid_i` strobe with a target class, a 4-bit minor-register field (`crm_i`) and a 3-bit secondary opcode (`op2_i`). The block turns that write into single-cycle command strobes for the instruction cache, both data caches, the instruction and data TLBs, a write buffer and a four-entry read buffer. The 32-bit operand goes out alongside the strobes as the target address.

A fixed matrix of (class, op2, crm) values selects the command. Some commands act on a whole structure and others on one entry. Read-buffer load commands take an entry index and an access-size type from fields of `crm_i`. Any encoding outside the matrix raises an error pulse and issues no command. The caches, TLBs and buffers themselves live elsewhere.

Top module: `maint_decoder`

## Requirements
- R1: While `rst_ni` is low, every strobe, `err_o`, `rb_idx_o`, `rb_type_o` and `addr_o` are zero.
- R2: Each strobe and `err_o` rises only in the cycle after a cycle with `valid_i` high, and lasts one cycle. Every accepted `valid_i` produces either at least one strobe or `err_o`. Back-to-back valids produce back-to-back responses.
- R3: Class 0 (cache) with op2=0: crm=7 pulses `ic_inv_all_o` and `dc_inv_all_o` together, crm=5 pulses only `ic_inv_all_o`, and crm=6 pulses only `dc_inv_all_o`.
- R4: Class 0 with op2=1: crm=6 pulses `dc_inv_line_o` and crm=10 pulses `dc_clean_line_o`. Both act on the operand address in both data caches.
- R5: Class 0 with op2=4 and crm=10 pulses `wb_drain_o` alone.
- R6: Class 1 (TLB) with op2=0: crm=7 pulses `itlb_inv_all_o` and `dtlb_inv_all_o` together, crm=5 pulses only `itlb_inv_all_o`, and crm=6 pulses only `dtlb_inv_all_o`.
- R7: Class 1 with op2=1 and crm=6 pulses `dtlb_inv_entry_o`.
- R8: Class 2 (read buffer): op2=0 with crm=0 pulses `rb_inv_all_o`. op2=1 with crm below 4 pulses `rb_inv_entry_o` with `rb_idx_o` = crm[1:0].
- R9: Class 2 with op2=2 and crm[3:2] not equal to 3 pulses `rb_load_o` with `rb_idx_o` = crm[1:0] and `rb_type_o` = crm[3:2]+1, giving a type of 1 to 3. When crm[3:2]=3 the type would be 4, so the write is an error. `rb_idx_o` and `rb_type_o` are zero whenever no read-buffer entry command fires.
- R10: Class 3 is reserved. Every (class, op2, crm) combination not listed in R3 to R9 pulses `err_o` with no strobe.
- R11: `addr_o` takes `operand_i` on every accepted write, including erroneous ones, and holds it until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Maintenance write strobe |
| target_i | input | 2 | Class: 0 cache, 1 TLB, 2 read buffer, 3 reserved |
| crm_i | input | 4 | Minor register field |
| op2_i | input | 3 | Secondary opcode field |
| operand_i | input | 32 | Write operand |
| ic_inv_all_o | output | 1 | Invalidate whole instruction cache |
| dc_inv_all_o | output | 1 | Invalidate both data caches |
| dc_inv_line_o | output | 1 | Invalidate one data-cache line by address |
| dc_clean_line_o | output | 1 | Clean one data-cache line by address |
| wb_drain_o | output | 1 | Drain write buffer |
| itlb_inv_all_o | output | 1 | Invalidate instruction TLB |
| dtlb_inv_all_o | output | 1 | Invalidate data TLB |
| dtlb_inv_entry_o | output | 1 | Invalidate one data-TLB entry by address |
| rb_inv_all_o | output | 1 | Invalidate all read-buffer entries |
| rb_inv_entry_o | output | 1 | Invalidate one read-buffer entry |
| rb_load_o | output | 1 | Load one read-buffer entry |
| rb_idx_o | output | 2 | Read-buffer entry index |
| rb_type_o | output | 3 | Read-buffer load type (1 to 3) |
| err_o | output | 1 | Unrecognised encoding |
| addr_o | output | 32 | Operand captured with the command |

## Verification
Decode state is held for only one cycle, so a wrong decode shows up at the ports in the cycle right after the write. It appears as a missing, extra or misplaced strobe, or as a wrong error pulse. A fault in the operand register shows as an `addr_o` that differs from the last write or drifts during idle cycles, and an idle-cycle check catches it. Every one of the 512 class/op2/crm combinations is compared against an independent model, so the fault cannot hide in an encoding that goes unexercised.

// File: rtl/maint_pkg.sv
package maint_pkg;
  localparam int CRM_W      = 4;
  localparam int OP2_W      = 3;
  localparam int RB_IDX_W   = 2;
  localparam int RB_TYPE_W  = 3;
  localparam int STRB_N     = 11;

  typedef enum logic [1:0] {
    TGT_CACHE = 2'd0,
    TGT_TLB   = 2'd1,
    TGT_RBUF  = 2'd2,
    TGT_RSVD  = 2'd3
  } tgt_e;

  typedef struct packed {
    logic                 ic_inv_all;
    logic                 dc_inv_all;
    logic                 dc_inv_line;
    logic                 dc_clean_line;
    logic                 wb_drain;
    logic                 itlb_inv_all;
    logic                 dtlb_inv_all;
    logic                 dtlb_inv_entry;
    logic                 rb_inv_all;
    logic                 rb_inv_entry;
    logic                 rb_load;
    logic [RB_IDX_W-1:0]  rb_idx;
    logic [RB_TYPE_W-1:0] rb_type;
  } maint_cmd_t;

  localparam maint_cmd_t CMD_NONE = '0;
endpackage

// File: rtl/maint_cache_dec.sv
module maint_cache_dec
  import maint_pkg::*;
(
  input  logic [CRM_W-1:0] crm_i,
  input  logic [OP2_W-1:0] op2_i,
  output maint_cmd_t       cmd_o,
  output logic             known_o
);
  always_comb begin
    cmd_o   = CMD_NONE;
    known_o = 1'b1;
    case ({op2_i, crm_i})
      {3'd0, 4'd7}: begin
        cmd_o.ic_inv_all = 1'b1;
        cmd_o.dc_inv_all = 1'b1;
      end
      {3'd0, 4'd5}:  cmd_o.ic_inv_all    = 1'b1;
      {3'd0, 4'd6}:  cmd_o.dc_inv_all    = 1'b1;
      {3'd1, 4'd6}:  cmd_o.dc_inv_line   = 1'b1;
      {3'd1, 4'd10}: cmd_o.dc_clean_line = 1'b1;
      {3'd4, 4'd10}: cmd_o.wb_drain      = 1'b1;
      default:       known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/maint_tlb_dec.sv
module maint_tlb_dec
  import maint_pkg::*;
(
  input  logic [CRM_W-1:0] crm_i,
  input  logic [OP2_W-1:0] op2_i,
  output maint_cmd_t       cmd_o,
  output logic             known_o
);
  always_comb begin
    cmd_o   = CMD_NONE;
    known_o = 1'b1;
    case ({op2_i, crm_i})
      {3'd0, 4'd7}: begin
        cmd_o.itlb_inv_all = 1'b1;
        cmd_o.dtlb_inv_all = 1'b1;
      end
      {3'd0, 4'd5}: cmd_o.itlb_inv_all   = 1'b1;
      {3'd0, 4'd6}: cmd_o.dtlb_inv_all   = 1'b1;
      {3'd1, 4'd6}: cmd_o.dtlb_inv_entry = 1'b1;
      default:      known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/maint_rbuf_dec.sv
module maint_rbuf_dec
  import maint_pkg::*;
(
  input  logic [CRM_W-1:0] crm_i,
  input  logic [OP2_W-1:0] op2_i,
  output maint_cmd_t       cmd_o,
  output logic             known_o
);
  localparam logic [1:0] TYPE_OVF = 2'b11;  // type field that would give type 4

  logic [RB_IDX_W-1:0] idx_f;
  logic [1:0]          type_f;

  assign idx_f  = crm_i[RB_IDX_W-1:0];
  assign type_f = crm_i[3:2];

  always_comb begin
    cmd_o   = CMD_NONE;
    known_o = 1'b1;
    if (op2_i == 3'd0 && crm_i == '0) begin
      cmd_o.rb_inv_all = 1'b1;
    end else if (op2_i == 3'd1 && type_f == 2'b00) begin
      cmd_o.rb_inv_entry = 1'b1;
      cmd_o.rb_idx       = idx_f;
    end else if (op2_i == 3'd2 && type_f != TYPE_OVF) begin
      cmd_o.rb_load = 1'b1;
      cmd_o.rb_idx  = idx_f;
      cmd_o.rb_type = {1'b0, type_f} + 3'd1;
    end else begin
      known_o = 1'b0;
    end
  end
endmodule

// File: rtl/maint_decoder.sv
module maint_decoder
  import maint_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [1:0]           target_i,
  input  logic [CRM_W-1:0]     crm_i,
  input  logic [OP2_W-1:0]     op2_i,
  input  logic [ADDR_W-1:0]    operand_i,
  output logic                 ic_inv_all_o,
  output logic                 dc_inv_all_o,
  output logic                 dc_inv_line_o,
  output logic                 dc_clean_line_o,
  output logic                 wb_drain_o,
  output logic                 itlb_inv_all_o,
  output logic                 dtlb_inv_all_o,
  output logic                 dtlb_inv_entry_o,
  output logic                 rb_inv_all_o,
  output logic                 rb_inv_entry_o,
  output logic                 rb_load_o,
  output logic [RB_IDX_W-1:0]  rb_idx_o,
  output logic [RB_TYPE_W-1:0] rb_type_o,
  output logic                 err_o,
  output logic [ADDR_W-1:0]    addr_o
);
  maint_cmd_t cache_cmd, tlb_cmd, rbuf_cmd, sel_cmd, cmd_q;
  logic       cache_ok, tlb_ok, rbuf_ok, sel_ok;
  logic       err_q;
  logic [ADDR_W-1:0] addr_q;

  maint_cache_dec u_cache (.crm_i(crm_i), .op2_i(op2_i), .cmd_o(cache_cmd), .known_o(cache_ok));
  maint_tlb_dec   u_tlb   (.crm_i(crm_i), .op2_i(op2_i), .cmd_o(tlb_cmd),   .known_o(tlb_ok));
  maint_rbuf_dec  u_rbuf  (.crm_i(crm_i), .op2_i(op2_i), .cmd_o(rbuf_cmd),  .known_o(rbuf_ok));

  always_comb begin
    sel_cmd = CMD_NONE;
    sel_ok  = 1'b0;
    case (target_i)
      TGT_CACHE: begin sel_cmd = cache_cmd; sel_ok = cache_ok; end
      TGT_TLB:   begin sel_cmd = tlb_cmd;   sel_ok = tlb_ok;   end
      TGT_RBUF:  begin sel_cmd = rbuf_cmd;  sel_ok = rbuf_ok;  end
      default:   begin sel_cmd = CMD_NONE;  sel_ok = 1'b0;     end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_NONE;
      err_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      cmd_q <= valid_i ? sel_cmd : CMD_NONE;
      err_q <= valid_i && !sel_ok;
      if (valid_i) addr_q <= operand_i;
    end
  end

  assign ic_inv_all_o     = cmd_q.ic_inv_all;
  assign dc_inv_all_o     = cmd_q.dc_inv_all;
  assign dc_inv_line_o    = cmd_q.dc_inv_line;
  assign dc_clean_line_o  = cmd_q.dc_clean_line;
  assign wb_drain_o       = cmd_q.wb_drain;
  assign itlb_inv_all_o   = cmd_q.itlb_inv_all;
  assign dtlb_inv_all_o   = cmd_q.dtlb_inv_all;
  assign dtlb_inv_entry_o = cmd_q.dtlb_inv_entry;
  assign rb_inv_all_o     = cmd_q.rb_inv_all;
  assign rb_inv_entry_o   = cmd_q.rb_inv_entry;
  assign rb_load_o        = cmd_q.rb_load;
  assign rb_idx_o         = cmd_q.rb_idx;
  assign rb_type_o        = cmd_q.rb_type;
  assign err_o            = err_q;
  assign addr_o           = addr_q;

  logic [STRB_N-1:0] strb;
  assign strb = {ic_inv_all_o, dc_inv_all_o, dc_inv_line_o, dc_clean_line_o, wb_drain_o,
                 itlb_inv_all_o, dtlb_inv_all_o, dtlb_inv_entry_o,
                 rb_inv_all_o, rb_inv_entry_o, rb_load_o};

  // R10
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (strb == '0));

  // R2
  pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((strb != '0) || err_o) |-> $past(valid_i));

  // R2
  valid_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((strb != '0) || err_o));

  // R9
  rb_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_load_o |-> (rb_type_o != '0 && rb_type_o <= 3'd3));

  // R5
  wb_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_drain_o |-> ($countones(strb) == 1));

  // R11
  addr_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (addr_o == $past(operand_i)));

  // R11
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(addr_o));
endmodule

// File: tb/maint_decoder_bench.sv
`timescale 1ns/1ps
module maint_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  tgt = '0;
  logic [3:0]  crm = '0;
  logic [2:0]  op2 = '0;
  logic [31:0] opnd = '0;

  logic ic_ia, dc_ia, dc_il, dc_cl, wb_dr, it_ia, dt_ia, dt_ie, rb_ia, rb_ie, rb_ld, err;
  logic [1:0]  rb_idx;
  logic [2:0]  rb_type;
  logic [31:0] addr;

  always #5 clk = ~clk;

  maint_decoder u_maint_decoder (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .target_i(tgt), .crm_i(crm),
    .op2_i(op2), .operand_i(opnd),
    .ic_inv_all_o(ic_ia), .dc_inv_all_o(dc_ia), .dc_inv_line_o(dc_il),
    .dc_clean_line_o(dc_cl), .wb_drain_o(wb_dr), .itlb_inv_all_o(it_ia),
    .dtlb_inv_all_o(dt_ia), .dtlb_inv_entry_o(dt_ie), .rb_inv_all_o(rb_ia),
    .rb_inv_entry_o(rb_ie), .rb_load_o(rb_ld), .rb_idx_o(rb_idx),
    .rb_type_o(rb_type), .err_o(err), .addr_o(addr)
  );

  typedef struct {
    logic [10:0] s;
    logic [1:0]  idx;
    logic [2:0]  ty;
    logic        e;
    logic [31:0] a;
    string       tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] last_addr = '0;

  wire [10:0] act_s = {ic_ia, dc_ia, dc_il, dc_cl, wb_dr, it_ia, dt_ia, dt_ie, rb_ia, rb_ie, rb_ld};

  function automatic exp_t model(input logic [1:0] t, input logic [3:0] c,
                                 input logic [2:0] o, input logic [31:0] a);
    exp_t x;
    x.s = '0; x.idx = '0; x.ty = '0; x.e = 1'b0; x.a = a; x.tag = "R10";
    if (t == 2'd0) begin
      if      (o == 0 && c == 7)  begin x.s = 11'b11000000000; x.tag = "R3"; end
      else if (o == 0 && c == 5)  begin x.s = 11'b10000000000; x.tag = "R3"; end
      else if (o == 0 && c == 6)  begin x.s = 11'b01000000000; x.tag = "R3"; end
      else if (o == 1 && c == 6)  begin x.s = 11'b00100000000; x.tag = "R4"; end
      else if (o == 1 && c == 10) begin x.s = 11'b00010000000; x.tag = "R4"; end
      else if (o == 4 && c == 10) begin x.s = 11'b00001000000; x.tag = "R5"; end
      else x.e = 1'b1;
    end else if (t == 2'd1) begin
      if      (o == 0 && c == 7) begin x.s = 11'b00000110000; x.tag = "R6"; end
      else if (o == 0 && c == 5) begin x.s = 11'b00000100000; x.tag = "R6"; end
      else if (o == 0 && c == 6) begin x.s = 11'b00000010000; x.tag = "R6"; end
      else if (o == 1 && c == 6) begin x.s = 11'b00000001000; x.tag = "R7"; end
      else x.e = 1'b1;
    end else if (t == 2'd2) begin
      if (o == 0 && c == 0) begin x.s = 11'b00000000100; x.tag = "R8"; end
      else if (o == 1 && c < 4) begin
        x.s = 11'b00000000010; x.idx = c[1:0]; x.tag = "R8";
      end else if (o == 2 && c[3:2] != 2'b11) begin
        x.s = 11'b00000000001; x.idx = c[1:0]; x.ty = 3'(c[3:2]) + 3'd1; x.tag = "R9";
      end else x.e = 1'b1;
    end else begin
      x.e = 1'b1;
    end
    return x;
  endfunction

  task automatic send(input logic [1:0] t, input logic [3:0] c, input logic [2:0] o,
                      input logic [31:0] a);
    @(negedge clk);
    valid = 1'b1; tgt = t; crm = c; op2 = o; opnd = a;
    q.push_back(model(t, c, o, a));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0;
      opnd = 32'hDEAD_0000 + 32'(i);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      logic sampled;
      @(posedge clk);
      sampled = valid;
      #1;
      if (rst_n) begin
        if (sampled) begin
          exp_t x;
          total++;
          if (q.size() == 0) begin
            bad++;
            $display("FAIL %s: response with no expected item", "R2");
          end else begin
            x = q.pop_front();
            if (act_s !== x.s || err !== x.e || rb_idx !== x.idx || rb_type !== x.ty ||
                addr !== x.a) begin
              bad++;
              $display("FAIL %s: act s=%b e=%b idx=%0d ty=%0d a=%h exp s=%b e=%b idx=%0d ty=%0d a=%h",
                       x.tag, act_s, err, rb_idx, rb_type, addr, x.s, x.e, x.idx, x.ty, x.a);
            end
            last_addr = x.a;
          end
        end else begin
          // R2 idle: no pulse; R11 address held
          total++;
          if (act_s !== '0 || err !== 1'b0 || addr !== last_addr) begin
            bad++;
            $display("FAIL R2/R11 idle: act s=%b e=%b a=%h exp s=0 e=0 a=%h",
                     act_s, err, addr, last_addr);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: act=hung exp=done");
    finish_run();
  end

  initial begin
    opnd = 32'hFFFF_FFFF; valid = 1'b1; tgt = 2'd0; crm = 4'd7;
    repeat (3) @(posedge clk);
    #2;
    total++;  // R1 reset state
    if (act_s !== '0 || err !== 1'b0 || rb_idx !== '0 || rb_type !== '0 || addr !== '0) begin
      bad++;
      $display("FAIL R1: act s=%b e=%b idx=%0d ty=%0d a=%h exp all zero",
               act_s, err, rb_idx, rb_type, addr);
    end
    @(negedge clk); valid = 1'b0; opnd = '0;
    rst_n = 1'b1;
    idle(2);

    // R3 cache whole-structure invalidates
    send(2'd0, 4'd7, 3'd0, 32'h1000_0007); idle(1);
    send(2'd0, 4'd5, 3'd0, 32'h1000_0005); idle(1);
    send(2'd0, 4'd6, 3'd0, 32'h1000_0006); idle(1);
    // R4 line operations
    send(2'd0, 4'd6, 3'd1, 32'h8000_1240); idle(1);
    send(2'd0, 4'd10, 3'd1, 32'h8000_2280); idle(1);
    // R5 drain
    send(2'd0, 4'd10, 3'd4, 32'h0BAD_F00D); idle(2);
    // R6 / R7 TLB
    send(2'd1, 4'd7, 3'd0, 32'h2);
    send(2'd1, 4'd5, 3'd0, 32'h3);
    send(2'd1, 4'd6, 3'd0, 32'h4);
    send(2'd1, 4'd6, 3'd1, 32'hC000_3000); idle(1);
    // R8 read buffer
    send(2'd2, 4'd0, 3'd0, 32'h55);
    send(2'd2, 4'd3, 3'd1, 32'h56);
    send(2'd2, 4'd4, 3'd1, 32'h57);  // R8 boundary: crm=4 is an error
    // R9 loads including type-4 boundary
    send(2'd2, 4'd11, 3'd2, 32'h6000_0000);
    send(2'd2, 4'd12, 3'd2, 32'h6000_0004);
    idle(1);
    // R10 reserved class and near-miss encodings
    send(2'd3, 4'd7, 3'd0, 32'h77); idle(1);
    send(2'd0, 4'd10, 3'd0, 32'h78);
    send(2'd1, 4'd6, 3'd2, 32'h79); idle(3);

    // exhaustive sweep, alternating back-to-back and spaced
    for (int t = 0; t < 4; t++)
      for (int o = 0; o < 8; o++)
        for (int c = 0; c < 16; c++) begin
          send(2'(t), 4'(c), 3'(o), 32'hA500_0000 ^ (32'(t) << 12) ^ (32'(o) << 8) ^ 32'(c * 17));
          if (c[0]) idle(1);
        end
    idle(4);
    finish_run();
  end
endmodule